// File: doc/BRIEF.md
# Weighted Two-Queue Transmit Arbiter

This block decides, one frame at a time, whether the transmitter takes its next frame from a high-priority queue or a low-priority queue. Each queue reports whether it holds work. Each queue also has a start and a stop command and its own running flag. A 3-bit weight code sets how many high-priority frames may go out before one low-priority frame is owed. The largest code selects strict priority.

The grant is a registered state. It moves only at frame boundaries, so a frame that has begun is never cut off. The transmitter pulses `frame_end` in the last cycle of a frame, and the next grant shows in the following cycle. A stop command waits for the end of the queue's current frame, then clears the running flag and pulses a completion event. Credit for the high queue is counted per frame. The count resets whenever a decision finds no eligible high-priority work, and whenever a low-priority frame is granted.

The controller is a three-state machine:
- `ST_IDLE`: no grant. A decision is made every cycle.
- `ST_SEND_HI`: the high queue is granted.
- `ST_SEND_LO`: the low queue is granted.

Transitions are evaluated in `ST_IDLE` on every cycle, and in the two send states only on `frame_end`:
- `pick_hi` goes to `ST_SEND_HI`.
- `pick_lo` goes to `ST_SEND_LO`.
- `pick_none` goes to `ST_IDLE`.

Top module: `tx_wrr_arbiter`

## Requirements
- R1: After reset, neither grant is asserted, both running flags are 0 and neither stop-done event is asserted.
- R2: At most one grant is asserted at a time. A grant holds until `frame_end`, and the new grant shows in the cycle after `frame_end`.
- R3: When both queues stay eligible, weight codes 0 to 6 give this many high-priority frames before each low-priority frame: code 0 gives 1, code 1 gives 2, code 2 gives 4, code 3 gives 6, code 4 gives 8, code 5 gives 10, code 6 gives 12. The high-priority grant comes first.
- R4: Weight code 7 (all ones) gives strict priority. The low queue is granted only at a decision where the high queue is not eligible.
- R5: If a decision finds the high queue not eligible, the high-priority count returns to zero. The next high-priority run then gets its full quota.
- R6: When the low queue is not eligible, high-priority frames keep being granted past the quota. Once the low queue becomes eligible with the quota used up, it is granted at the next boundary.
- R7: With no grant, a queue that is running and has work is granted in the cycle after it becomes eligible. If both queues qualify, high priority wins.
- R8: A start pulse on a stopped queue sets its running flag in the next cycle.
- R9: A stop pulse on a queue that is not granted clears its running flag in the next cycle and pulses its stop-done output for exactly one cycle.
- R10: A stop pulse on the granted queue keeps the grant and the running flag until `frame_end`. In the cycle after that, the running flag is 0, stop-done pulses, and the queue is not granted again.
- R11: A start pulse while a stop is still pending cancels the stop. The queue stays running, no stop-done occurs, and the queue can be granted again.
- R12: Start and stop pulsed in the same cycle act as a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hi_avail | input | 1 | High-priority queue holds a frame |
| lo_avail | input | 1 | Low-priority queue holds a frame |
| weight_code | input | 3 | High-to-low ratio code; 7 selects strict priority |
| hi_start | input | 1 | Start pulse, high queue |
| hi_stop | input | 1 | Stop pulse, high queue |
| lo_start | input | 1 | Start pulse, low queue |
| lo_stop | input | 1 | Stop pulse, low queue |
| frame_end | input | 1 | Last cycle of the frame in progress |
| grant_hi | output | 1 | High queue granted |
| grant_lo | output | 1 | Low queue granted |
| hi_running | output | 1 | High queue running |
| lo_running | output | 1 | Low queue running |
| hi_stop_done | output | 1 | One-cycle pulse when a high-queue stop completes |
| lo_stop_done | output | 1 | One-cycle pulse when a low-queue stop completes |

## Verification
Every result of this block lands exactly one clock edge after its cause:
- A grant change appears one edge after `frame_end`, or one edge after eligibility rises while idle.
- A running flag changes one edge after its command.
- A stop-done pulse appears one edge after the command, or one edge after the closing `frame_end` if a frame was in progress.

The bench drives every stimulus on a falling edge and reads the outputs on the next falling edge. Each reading therefore sees the effect of exactly one rising edge. For the ratio tests the bench ends one frame per call and records which queue held the grant. This builds a grant sequence that is compared against the quota table.

// File: rtl/tx_arb_pkg.sv
package tx_arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SEND_HI = 2'd1,
        ST_SEND_LO = 2'd2
    } arb_state_t;

    localparam int NUM_Q = 2;
    localparam int Q_HI  = 0;
    localparam int Q_LO  = 1;

endpackage

// File: rtl/tx_queue_ctrl.sv
// Per-queue run/stop bookkeeping: start, deferred stop, completion pulse.
module tx_queue_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start_cmd,
    input  logic stop_cmd,
    input  logic active,
    input  logic frame_end,
    output logic running,
    output logic grantable,
    output logic stop_done
);

    logic pending_q;
    logic stop_req;
    logic can_close;

    // A stop request is either a fresh pulse or a pending stop that no start cancelled.
    assign stop_req  = stop_cmd || (pending_q && !start_cmd);
    // The stop can complete when this queue is not mid-frame.
    assign can_close = !active || frame_end;
    assign grantable = running && !pending_q && !stop_cmd;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running   <= 1'b0;
            pending_q <= 1'b0;
            stop_done <= 1'b0;
        end else begin
            stop_done <= 1'b0;
            if (stop_req) begin
                if (can_close) begin
                    running   <= 1'b0;
                    pending_q <= 1'b0;
                    stop_done <= 1'b1;
                end else begin
                    pending_q <= 1'b1;
                end
            end else if (start_cmd) begin
                running   <= 1'b1;
                pending_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/tx_credit_ctr.sv
// Counts high-priority frames granted since the last low grant or reset.
module tx_credit_ctr #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    input  logic              take_hi,
    input  logic              clear,
    output logic              quota_left,
    output logic              strict_mode
);

    localparam int MAX_QUOTA = 2 * ((1 << CODE_W) - 2);
    localparam int CNT_W     = $clog2(MAX_QUOTA + 3);

    logic [CNT_W-1:0] credit_q;
    logic [CNT_W-1:0] limit;

    // Quota is 1 for code 0, otherwise twice the code.
    always_comb begin
        if (code == '0) limit = CNT_W'(1);
        else            limit = CNT_W'({code, 1'b0});
    end

    assign strict_mode = &code;
    assign quota_left  = credit_q < limit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            credit_q <= '0;
        end else if (clear) begin
            credit_q <= '0;
        end else if (take_hi && quota_left) begin
            credit_q <= credit_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/tx_wrr_fsm.sv
// Grant state machine: decides only when idle or on a frame boundary.
module tx_wrr_fsm
    import tx_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_end,
    input  logic hi_ok,
    input  logic lo_ok,
    input  logic quota_left,
    input  logic strict_mode,
    output logic grant_hi,
    output logic grant_lo,
    output logic take_hi,
    output logic clear_credit
);

    arb_state_t state_q, state_d;
    logic decide;
    logic pick_hi;
    logic pick_lo;

    assign pick_hi = hi_ok && (strict_mode || quota_left || !lo_ok);
    assign pick_lo = !pick_hi && lo_ok;

    always_comb begin
        decide = 1'b0;
        unique case (state_q)
            ST_IDLE:    decide = 1'b1;
            ST_SEND_HI: decide = frame_end;
            ST_SEND_LO: decide = frame_end;
            default:    decide = 1'b1;
        endcase
        state_d      = state_q;
        take_hi      = 1'b0;
        clear_credit = 1'b0;
        if (decide) begin
            clear_credit = !pick_hi;
            if (pick_hi) begin
                state_d = ST_SEND_HI;
                take_hi = 1'b1;
            end else if (pick_lo) begin
                state_d = ST_SEND_LO;
            end else begin
                state_d = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        grant_hi = 1'b0;
        grant_lo = 1'b0;
        unique case (state_q)
            ST_SEND_HI: grant_hi = 1'b1;
            ST_SEND_LO: grant_lo = 1'b1;
            default:    ;
        endcase
    end

endmodule

// File: rtl/tx_wrr_arbiter.sv
module tx_wrr_arbiter
    import tx_arb_pkg::*;
#(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_avail,
    input  logic              lo_avail,
    input  logic [CODE_W-1:0] weight_code,
    input  logic              hi_start,
    input  logic              hi_stop,
    input  logic              lo_start,
    input  logic              lo_stop,
    input  logic              frame_end,
    output logic              grant_hi,
    output logic              grant_lo,
    output logic              hi_running,
    output logic              lo_running,
    output logic              hi_stop_done,
    output logic              lo_stop_done
);

    logic [NUM_Q-1:0] start_v, stop_v, active_v, run_v, ok_v, done_v, avail_v;
    logic take_hi, clear_credit, quota_left, strict_mode;

    assign start_v  = {lo_start, hi_start};
    assign stop_v   = {lo_stop, hi_stop};
    assign avail_v  = {lo_avail, hi_avail};
    assign active_v = {grant_lo, grant_hi};

    for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
        tx_queue_ctrl u_ctrl (
            .clk       (clk),
            .rst_n     (rst_n),
            .start_cmd (start_v[q]),
            .stop_cmd  (stop_v[q]),
            .active    (active_v[q]),
            .frame_end (frame_end),
            .running   (run_v[q]),
            .grantable (ok_v[q]),
            .stop_done (done_v[q])
        );
    end

    tx_credit_ctr #(.CODE_W(CODE_W)) u_credit (
        .clk         (clk),
        .rst_n       (rst_n),
        .code        (weight_code),
        .take_hi     (take_hi),
        .clear       (clear_credit),
        .quota_left  (quota_left),
        .strict_mode (strict_mode)
    );

    tx_wrr_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_end    (frame_end),
        .hi_ok        (ok_v[Q_HI] && avail_v[Q_HI]),
        .lo_ok        (ok_v[Q_LO] && avail_v[Q_LO]),
        .quota_left   (quota_left),
        .strict_mode  (strict_mode),
        .grant_hi     (grant_hi),
        .grant_lo     (grant_lo),
        .take_hi      (take_hi),
        .clear_credit (clear_credit)
    );

    assign hi_running   = run_v[Q_HI];
    assign lo_running   = run_v[Q_LO];
    assign hi_stop_done = done_v[Q_HI];
    assign lo_stop_done = done_v[Q_LO];

endmodule

// File: rtl/tx_wrr_arbiter_chk.sv
module tx_wrr_arbiter_chk (
    input logic clk,
    input logic rst_n,
    input logic hi_start,
    input logic hi_stop,
    input logic frame_end,
    input logic grant_hi,
    input logic grant_lo,
    input logic hi_running,
    input logic lo_running,
    input logic hi_stop_done,
    input logic lo_stop_done
);

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_hi && grant_lo)); // R2
    AST_HI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        grant_hi && !frame_end |=> grant_hi); // R2
    AST_LO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        grant_lo && !frame_end |=> grant_lo); // R2
    AST_HI_GRANT_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        grant_hi |-> hi_running); // R10
    AST_LO_GRANT_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        grant_lo |-> lo_running); // R10
    AST_HI_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        hi_stop_done |=> !hi_stop_done); // R9
    AST_LO_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        lo_stop_done |=> !lo_stop_done); // R9
    AST_HI_DONE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        hi_stop_done |-> !hi_running); // R9
    AST_LO_DONE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        lo_stop_done |-> !lo_running); // R9
    AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        hi_start && !hi_stop |=> hi_running); // R8

endmodule

bind tx_wrr_arbiter tx_wrr_arbiter_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hi_start     (hi_start),
    .hi_stop      (hi_stop),
    .frame_end    (frame_end),
    .grant_hi     (grant_hi),
    .grant_lo     (grant_lo),
    .hi_running   (hi_running),
    .lo_running   (lo_running),
    .hi_stop_done (hi_stop_done),
    .lo_stop_done (lo_stop_done)
);

// File: tb/tb_tx_wrr_arbiter.sv
module tb_tx_wrr_arbiter;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hi_avail = 1'b0, lo_avail = 1'b0;
    logic [2:0] weight_code = 3'd0;
    logic hi_start = 1'b0, hi_stop = 1'b0, lo_start = 1'b0, lo_stop = 1'b0;
    logic frame_end = 1'b0;
    logic grant_hi, grant_lo, hi_running, lo_running, hi_stop_done, lo_stop_done;

    int n_checks = 0;
    int n_errors = 0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    tx_wrr_arbiter dut (
        .clk(clk), .rst_n(rst_n), .hi_avail(hi_avail), .lo_avail(lo_avail),
        .weight_code(weight_code), .hi_start(hi_start), .hi_stop(hi_stop),
        .lo_start(lo_start), .lo_stop(lo_stop), .frame_end(frame_end),
        .grant_hi(grant_hi), .grant_lo(grant_lo), .hi_running(hi_running),
        .lo_running(lo_running), .hi_stop_done(hi_stop_done), .lo_stop_done(lo_stop_done)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // 0 = no grant, 1 = high, 2 = low
    function automatic int who();
        return grant_hi ? 1 : (grant_lo ? 2 : 0);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        hi_avail = 0; lo_avail = 0; hi_start = 0; hi_stop = 0;
        lo_start = 0; lo_stop = 0; frame_end = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic start_both();
        hi_start = 1; lo_start = 1;
        @(negedge clk);
        hi_start = 0; lo_start = 0;
    endtask

    task automatic end_frame(output int owner);
        owner = who();
        frame_end = 1;
        @(negedge clk);
        frame_end = 0;
    endtask

    task automatic test_reset(); // R1
        do_reset();
        check("R1 grant", who(), 0);
        check("R1 running", int'({hi_running, lo_running}), 0);
        check("R1 stop_done", int'({hi_stop_done, lo_stop_done}), 0);
    endtask

    task automatic test_ratio(input int code); // R3, R2
        int lim;
        int got;
        lim = (code == 0) ? 1 : 2 * code;
        do_reset();
        weight_code = 3'(code);
        hi_avail = 1; lo_avail = 1;
        start_both();
        @(negedge clk);
        check("R8 start sets running", int'(hi_running & lo_running), 1);
        for (int k = 0; k < 2 * (lim + 1); k++) begin
            end_frame(got);
            check($sformatf("R3 code %0d frame %0d", code, k), got,
                  ((k % (lim + 1)) == lim) ? 2 : 1);
        end
    endtask

    task automatic test_hold(); // R2
        do_reset();
        weight_code = 3'd0; hi_avail = 1; lo_avail = 1;
        start_both();
        @(negedge clk);
        repeat (3) @(negedge clk);
        check("R2 grant held without frame_end", who(), 1);
        frame_end = 1;
        @(negedge clk);
        frame_end = 0;
        check("R2 grant moves cycle after frame_end", who(), 2);
    endtask

    task automatic test_strict(); // R4
        int got;
        do_reset();
        weight_code = 3'd7; hi_avail = 1; lo_avail = 1;
        start_both();
        @(negedge clk);
        for (int k = 0; k < 16; k++) begin
            end_frame(got);
            check("R4 strict keeps high", got, 1);
        end
        hi_avail = 0;
        end_frame(got);
        check("R4 low only when high ineligible", who(), 2);
    endtask

    task automatic test_early_reset(); // R5
        int got;
        do_reset();
        weight_code = 3'd2; hi_avail = 1; lo_avail = 0;
        start_both();
        @(negedge clk);
        end_frame(got);
        hi_avail = 0;
        end_frame(got);
        check("R5 idle after high empties", who(), 0);
        hi_avail = 1; lo_avail = 1;
        @(negedge clk);
        check("R7 high wins from idle", who(), 1);
        for (int k = 0; k < 5; k++) begin
            end_frame(got);
            check($sformatf("R5 full quota after reset frame %0d", k), got, (k == 4) ? 2 : 1);
        end
    endtask

    task automatic test_conserving(); // R6
        int got;
        do_reset();
        weight_code = 3'd0; hi_avail = 1; lo_avail = 0;
        start_both();
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            end_frame(got);
            check("R6 high past quota", got, 1);
        end
        check("R6 high still granted", who(), 1);
        lo_avail = 1;
        end_frame(got);
        check("R6 low after quota spent", who(), 2);
    endtask

    task automatic test_idle(); // R7
        int got;
        do_reset();
        weight_code = 3'd0;
        start_both();
        @(negedge clk);
        check("R7 no grant without work", who(), 0);
        lo_avail = 1;
        @(negedge clk);
        check("R7 low granted from idle", who(), 2);
        hi_avail = 1;
        end_frame(got);
        check("R7 high next", who(), 1);
    endtask

    task automatic test_stops(); // R9 R10 R11 R12
        int got;
        do_reset();
        weight_code = 3'd7; hi_avail = 1; lo_avail = 1;
        start_both();
        @(negedge clk);
        check("R9 setup high granted", who(), 1);
        lo_stop = 1;
        @(negedge clk);
        lo_stop = 0;
        check("R9 low stopped", int'(lo_running), 0);
        check("R9 low stop_done", int'(lo_stop_done), 1);
        @(negedge clk);
        check("R9 stop_done one cycle", int'(lo_stop_done), 0);
        hi_stop = 1;
        @(negedge clk);
        hi_stop = 0;
        check("R10 grant kept", who(), 1);
        check("R10 running kept", int'(hi_running), 1);
        check("R10 no early done", int'(hi_stop_done), 0);
        end_frame(got);
        check("R10 grant released", who(), 0);
        check("R10 running cleared", int'(hi_running), 0);
        check("R10 stop_done", int'(hi_stop_done), 1);
        @(negedge clk);
        check("R10 no regrant", who(), 0);
        // R11: start cancels pending stop
        start_both();
        @(negedge clk);
        hi_stop = 1;
        @(negedge clk);
        hi_stop = 0; hi_start = 1;
        @(negedge clk);
        hi_start = 0;
        end_frame(got);
        check("R11 still running", int'(hi_running), 1);
        check("R11 no stop_done", int'(hi_stop_done), 0);
        check("R11 regranted", who(), 1);
        // R12: start and stop together on an ungranted queue
        lo_start = 1; lo_stop = 1;
        @(negedge clk);
        lo_start = 0; lo_stop = 0;
        check("R12 stop wins running", int'(lo_running), 0);
        check("R12 stop wins done", int'(lo_stop_done), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            n_errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_hold();
        test_ratio(0);
        test_ratio(1);
        test_ratio(3);
        test_ratio(6);
        test_strict();
        test_early_reset();
        test_conserving();
        test_idle();
        test_stops();
        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule